// File: doc/BRIEF.md
# Multi-Axis Step Burst Generator

This block drives the step lines of several motor axes during coordinated motion. For each interpolation segment the host loads two values into every axis: a half-period, which sets the step rate, and a pulse count. The axis then emits exactly that many square-wave step pulses and raises its done flag. When the last axis finishes, a level interrupt asks the host for the next segment.

An axis given a count of zero emits nothing. It still stays busy for a programmed idle time, so that it lines up in time with the axes that are stepping. A global enable freezes all timing and forces every step line low. A single read address returns the done flags of all axes.

Address map (word addresses): axis `i` has its half-period register at `2*i` and its count/launch register at `2*i+1`. Address `2*AXES` acknowledges the interrupt when written and returns the status word when read.

Top module: `step_burst_gen`

## Requirements
- R1: After a launch with half-period H (H=0 is treated as 1), the step line of the axis stays low for H enabled cycles and then toggles every H enabled cycles. Each pulse is H cycles high and H cycles low. The first rising edge follows the launching write edge by H cycles.
- R2: A launch with count N>0 produces exactly N pulses. The done flag rises on the same clock edge as the falling edge of the N-th pulse, 2*H*N enabled cycles after the launch. While done is 1, the step line is low.
- R3: done=1 means the axis is ready. A write to the count address `2*i+1` while done is 1 launches a segment and clears the done flag from the next cycle. That write uses the half-period most recently written to address `2*i`.
- R4: A launch with count 0 emits no pulse. Its done flag rises H enabled cycles after the launch, where H is the staged half-period (0 treated as 1), so the axis idles for one interpolation period.
- R5: While an axis is busy (done=0), writes to either of its addresses are ignored. The running segment and the staged half-period are left unchanged.
- R6: irq rises on the cycle in which an axis completes and, as a result, every done flag is 1. If an acknowledge is written in that same cycle, the completion wins and irq is set.
- R7: Once set, irq stays high until a segment is launched on any axis or the acknowledge address `2*AXES` is written. In either case irq is 0 from the next cycle.
- R8: While en is 0, every step output is 0 in the same cycle and no axis timer advances. When en returns to 1, the segments resume where they stopped.
- R9: After reset all done flags are 1, all step outputs are 0, irq is 0 and every staged half-period is 0.
- R10: Reading address `2*AXES` returns the done flags in bits [AXES-1:0], with zeros above. Any other read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global enable; 0 freezes timing and holds step low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address (combinational read) |
| rd_data | output | DW | Read data |
| step | output | AXES | Step pulse per axis |
| done | output | AXES | Segment finished / ready flag per axis |
| irq | output | 1 | Level interrupt: all axes finished |

## Verification
Two functions can fall in the same cycle: the completion of the last running axis, which sets irq, and a host acknowledge write, which clears it. The bench launches one axis with H=2 and N=1 and places the acknowledge write on exactly the fourth edge after the launch. It then expects irq to remain high, because completion takes priority. A second collision, a write to an axis on the very edge at which that axis finishes, is judged by the reference model as ignored, since the axis was still busy when the write was sampled.

// File: rtl/step_burst_gen.sv
module step_burst_gen #(
  parameter int AXES = 5,
  parameter int PW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 16,
  localparam int AW  = $clog2(2*AXES+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [AXES-1:0] step,
  output logic [AXES-1:0] done,
  output logic            irq
);
  localparam int STAT = 2*AXES;

  logic [AXES-1:0] fin, go;
  logic [AXES-1:0] done_nx;
  logic            ack;

  assign ack = wr_en && (wr_addr == AW'(STAT));

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic [PW-1:0] per_q, half_q, tmr;
    logic [CW-1:0] tgt, cnt;
    logic          dn, lvl, zero, wrap, sel_p, sel_c;
    logic [PW-1:0] eff;

    assign sel_p = wr_en && (wr_addr == AW'(2*g));
    assign sel_c = wr_en && (wr_addr == AW'(2*g+1));
    assign go[g] = sel_c && dn;
    assign eff   = (per_q == '0) ? PW'(1) : per_q;
    assign wrap  = (tmr == half_q - PW'(1));
    assign fin[g] = !dn && en && wrap && (zero || (lvl && cnt == tgt));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        per_q  <= '0;
        half_q <= PW'(1);
        tmr    <= '0;
        tgt    <= '0;
        cnt    <= '0;
        lvl    <= 1'b0;
        zero   <= 1'b0;
        dn     <= 1'b1;
      end else begin
        if (sel_p && dn) per_q <= wr_data[PW-1:0];
        if (go[g]) begin
          tgt    <= wr_data[CW-1:0];
          cnt    <= '0;
          tmr    <= '0;
          lvl    <= 1'b0;
          half_q <= eff;
          zero   <= (wr_data[CW-1:0] == '0);
          dn     <= 1'b0;
        end else if (!dn && en) begin
          if (wrap) begin
            tmr <= '0;
            if (zero) begin
              dn <= 1'b1;
            end else if (!lvl) begin
              lvl <= 1'b1;
              cnt <= cnt + CW'(1);
            end else begin
              lvl <= 1'b0;
              if (cnt == tgt) dn <= 1'b1;
            end
          end else begin
            tmr <= tmr + PW'(1);
          end
        end
      end
    end

    assign done[g] = dn;
    assign step[g] = lvl & en;
  end

  assign done_nx = (done | fin) & ~go;

  always_ff @(posedge clk) begin
    if (!rst_n)                    irq <= 1'b0;
    else if ((|fin) && (&done_nx)) irq <= 1'b1;
    else if (ack || (|go))         irq <= 1'b0;
  end

  assign rd_data = (rd_addr == AW'(STAT)) ? DW'(done) : '0;
endmodule

// File: rtl/step_burst_chk.sv
module step_burst_chk #(
  parameter int AXES = 5,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [AXES-1:0] step,
  input logic [AXES-1:0] done,
  input logic            irq
);
  localparam int STAT = 2*AXES;

  p_step_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> step == '0);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step & done) == '0);

  p_irq_all_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> &done);

  p_irq_on_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$stable(done));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && wr_en && wr_addr == AW'(STAT)) |=> !irq);

  p_drop_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(done) & ~done) != '0) |-> $past(wr_en));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(done) && $stable(irq)));
endmodule

bind step_burst_gen step_burst_chk #(.AXES(AXES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
  .step(step), .done(done), .irq(irq)
);

// File: tb/tb_step_burst_gen.sv
`timescale 1ns/1ps
module tb_step_burst_gen;
  localparam int AXES = 5;
  localparam int DW   = 16;
  localparam int AW   = $clog2(2*AXES+1);
  localparam int STAT = 2*AXES;

  logic clk = 0, rst_n = 0, en = 1, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = AW'(STAT);
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AXES-1:0] step, done;
  logic irq;

  always #2.5 clk = ~clk;

  step_burst_gen #(.AXES(AXES), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .step(step), .done(done), .irq(irq));

  int checks = 0, bad = 0, cyc_n = 0;

  // reference model: active-cycle count since launch per axis
  int m_done[AXES], m_act[AXES], m_h[AXES], m_n[AXES], m_p[AXES], m_zero[AXES];
  int pre[AXES];
  bit m_irq, fin_any, launched, all_d;
  int ax;

  always @(posedge clk) begin
    cyc_n++;
    if (!rst_n) begin
      for (int i = 0; i < AXES; i++) begin
        m_done[i] = 1; m_act[i] = 0; m_h[i] = 1; m_n[i] = 0; m_p[i] = 0; m_zero[i] = 0;
      end
      m_irq = 0;
    end else begin
      fin_any = 0; launched = 0;
      for (int i = 0; i < AXES; i++) begin
        pre[i] = m_done[i];
        if (!m_done[i] && en) begin
          m_act[i]++;
          if (m_zero[i] ? (m_act[i] >= m_h[i]) : (m_act[i] >= 2*m_h[i]*m_n[i])) begin
            m_done[i] = 1; fin_any = 1;
          end
        end
      end
      if (wr_en && int'(wr_addr) < STAT) begin
        ax = int'(wr_addr) / 2;
        if (pre[ax] == 1) begin
          if (int'(wr_addr) % 2 == 0) m_p[ax] = int'(wr_data);
          else begin
            m_n[ax] = int'(wr_data); m_h[ax] = (m_p[ax] == 0) ? 1 : m_p[ax];
            m_zero[ax] = (m_n[ax] == 0); m_act[ax] = 0; m_done[ax] = 0; launched = 1;
          end
        end
      end
      all_d = 1;
      for (int i = 0; i < AXES; i++) if (!m_done[i]) all_d = 0;
      if (fin_any && all_d) m_irq = 1;
      else if (launched || (wr_en && int'(wr_addr) == STAT)) m_irq = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic compare();
    int es;
    for (int i = 0; i < AXES; i++) begin
      es = (!m_done[i] && !m_zero[i] && ((m_act[i] / m_h[i]) % 2 == 1) && en) ? 1 : 0;
      chk(step[i] == es[0], $sformatf("R1/R2/R4/R8 step[%0d]", i), step[i], es);
      chk(done[i] == m_done[i][0], $sformatf("R2/R3/R5 done[%0d]", i), done[i], m_done[i]);
    end
    chk(irq == m_irq, "R6/R7 irq", irq, m_irq);
    if (rd_addr == AW'(STAT))
      for (int i = 0; i < AXES; i++)
        chk(rd_data[i] == m_done[i][0], $sformatf("R10 status bit %0d", i), rd_data[i], m_done[i]);
  endtask

  task automatic cyc(input bit we, input int a, input int d);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = AW'(a); wr_data = DW'(d);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 0, 0);
  endtask

  task automatic seg(input int a, input int h, input int n);
    cyc(1, 2*a, h);
    cyc(1, 2*a+1, n);
  endtask

  task automatic wait_all(input int lim);
    for (int k = 0; k < lim; k++) begin
      cyc(0, 0, 0);
      if (&done) break;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc_n);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(done == '1, "R9 done after reset", done, 31);
    chk(step == '0, "R9 step after reset", step, 0);
    chk(irq == 0,   "R9 irq after reset", irq, 0);
    chk(rd_data == DW'(5'h1f), "R10 status after reset", rd_data, 31);
    rd_addr = AW'(3); #1;
    chk(rd_data == '0, "R10 other address reads zero", rd_data, 0);
    rd_addr = AW'(STAT);

    // R1 R2 single axis, then R6 irq
    seg(0, 3, 4);
    cyc(0, 0, 0);
    chk(done[0] == 0, "R3 launch clears done", done[0], 0);
    wait_all(100);
    idle(2);
    chk(irq == 1, "R6 irq after last finish", irq, 1);
    cyc(1, STAT, 0);
    cyc(0, 0, 0);
    chk(irq == 0, "R7 ack clears irq", irq, 0);

    // several axes at once, zero-count idle and zero period (R4)
    seg(1, 2, 5);
    seg(2, 20, 0);
    seg(3, 0, 3);
    seg(4, 1, 0);
    seg(0, 5, 2);
    idle(4);
    // R5 writes to busy axes ignored
    cyc(1, 2, 9);
    cyc(1, 3, 7);
    cyc(1, 0, 1);
    wait_all(200);
    idle(2);
    chk(irq == 1, "R6 irq after mixed segment", irq, 1);

    // R7 launch clears irq; R8 enable freeze
    seg(1, 4, 3);
    cyc(0, 0, 0);
    chk(irq == 0, "R7 launch clears irq", irq, 0);
    idle(5);
    en = 0;
    #1;
    chk(step == '0, "R8 step low while disabled", step, 0);
    idle(7);
    en = 1;
    wait_all(200);
    idle(2);

    // R6 ack in same cycle as last completion: completion wins
    seg(0, 2, 1);
    idle(3);
    cyc(1, STAT, 0);
    cyc(0, 0, 0);
    chk(irq == 1, "R6 set wins over same-cycle ack", irq, 1);
    cyc(1, STAT, 0);
    idle(2);
    chk(irq == 0, "R7 later ack clears", irq, 0);

    // write on the finishing edge is ignored (R5)
    seg(2, 1, 1);
    cyc(0, 0, 0);
    cyc(1, 5, 3);
    idle(3);
    chk(done[2] == 1, "R5 write on finishing edge ignored", done[2], 1);
    idle(3);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule